// File: doc/BRIEF.md
# Loopback Modem Status Generator

This block builds the modem status byte of a 16450-style serial port while the port runs in internal loopback. The four modem control outputs (data terminal ready, request to send and two auxiliary outputs) are turned back onto the four modem status inputs. Each looped status bit has a companion change flag that records when the looped value moved. These flags stay set until software reads the status byte.

A read is signalled by a one-cycle strobe. During that cycle the byte on the output is the value software sees. At the closing clock edge the register is cleared. When loopback is not active, external modem lines are treated as inactive. The register then only holds its value, apart from a read clearing it.

A two-state controller registers the loopback enable. In `LP_IDLE` the register holds. In `LP_TRACK` it follows the control bits. `LP_IDLE` moves to `LP_TRACK` on an edge where the loopback enable is sampled high. `LP_TRACK` returns to `LP_IDLE` on an edge where it is sampled low.

Top module: `msr_loopback_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `msr` is 0x00 and the controller is in `LP_IDLE`.
- R2: A change of `loop_en` sampled at clock edge k alters the register's update rule from edge k+1 onward. Tracking is active on an edge only if `loop_en` was high at the edge before it.
- R3: On a tracking edge the status bits are loaded from `mcr_ctl`: bit 7 (carrier detect) takes `mcr_ctl[3]` (second auxiliary output), bit 6 (ring) takes `mcr_ctl[2]` (first auxiliary output), bit 5 (DSR) takes `mcr_ctl[0]` (DTR), and bit 4 (CTS) takes `mcr_ctl[1]` (RTS).
- R4: On a tracking edge, bit 0 is set when RTS differs from the old bit 4, bit 1 when DTR differs from the old bit 5, and bit 3 when the second auxiliary output differs from the old bit 7. The old values are those before that edge.
- R5: On a tracking edge, bit 2 is set only when the old bit 6 is 1 and `mcr_ctl[2]` is 0. A rising ring value does not set it.
- R6: Bits 0 to 3 are sticky. Without a read they never go from 1 to 0.
- R7: At an edge with `rd_stb` high, the register is first cleared to zero. If tracking, the R3 to R5 update is then applied to that zero value in the same edge.
- R8: On a non-tracking edge, `msr` keeps its value whatever `mcr_ctl` does. A read on such an edge leaves 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | Loopback enable from the line/modem control logic |
| mcr_ctl | input | 4 | Modem control bits: [0] DTR, [1] RTS, [2] aux 1, [3] aux 2 |
| rd_stb | input | 1 | One-cycle status read strobe; clears the register at the edge |
| msr | output | 8 | Modem status byte: [7:4] DCD, RI, DSR, CTS; [3:0] their change flags |

## Verification
Every update of `msr` lands at the first rising edge after the inputs are driven. The exception is a change of `loop_en`, which takes effect one edge later because it passes through the controller's state register first. The bench drives inputs on the falling edge. At the following rising edge it computes the expected byte from the requirements, using the pre-edge tracking state. A monitor compares that byte at the next falling edge, so each comparison samples the single register stage exactly once. Reads are checked by the byte seen during the strobe cycle and by the byte after the clearing edge.

// File: rtl/msr_loop_pkg.sv
package msr_loop_pkg;
    localparam int CTL_W = 4;
    localparam int MSR_W = 8;
    localparam int HALF  = MSR_W / 2;

    // control bit positions
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_AUX1 = 2;
    localparam int C_AUX2 = 3;

    // status positions: change flags in low half, levels in high half
    localparam int S_CTS = 0;
    localparam int S_DSR = 1;
    localparam int S_RI  = 2;
    localparam int S_DCD = 3;

    typedef enum logic [0:0] {
        LP_IDLE  = 1'b0,
        LP_TRACK = 1'b1
    } loop_state_e;
endpackage

// File: rtl/msr_loop_ctl.sv
module msr_loop_ctl
    import msr_loop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    output logic loop_on
);
    loop_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_IDLE:  if (loop_en)  state_d = LP_TRACK;
            LP_TRACK: if (!loop_en) state_d = LP_IDLE;
            default:  state_d = LP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        loop_on = (state_q == LP_TRACK);
    end
endmodule

// File: rtl/msr_next_calc.sv
module msr_next_calc
    import msr_loop_pkg::*;
(
    input  logic [MSR_W-1:0] base,
    input  logic [CTL_W-1:0] ctl,
    input  logic             track,
    output logic [MSR_W-1:0] next
);
    logic [HALF-1:0] lvl_old, lvl_new, flg_old, flg_hit;

    always_comb begin
        lvl_old = base[MSR_W-1:HALF];
        flg_old = base[HALF-1:0];
        lvl_new[S_CTS] = ctl[C_RTS];
        lvl_new[S_DSR] = ctl[C_DTR];
        lvl_new[S_RI]  = ctl[C_AUX1];
        lvl_new[S_DCD] = ctl[C_AUX2];
    end

    genvar g;
    generate
        for (g = 0; g < HALF; g++) begin : g_flag
            if (g == S_RI) begin : g_trail
                assign flg_hit[g] = lvl_old[g] & ~lvl_new[g];
            end else begin : g_any
                assign flg_hit[g] = lvl_old[g] ^ lvl_new[g];
            end
        end
    endgenerate

    always_comb begin
        if (track) next = {lvl_new, flg_old | flg_hit};
        else       next = base;
    end
endmodule

// File: rtl/msr_loopback_gen.sv
module msr_loopback_gen
    import msr_loop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_en,
    input  logic [CTL_W-1:0] mcr_ctl,
    input  logic             rd_stb,
    output logic [MSR_W-1:0] msr
);
    logic             loop_on;
    logic [MSR_W-1:0] msr_q, base, msr_d;

    msr_loop_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .loop_en (loop_en),
        .loop_on (loop_on)
    );

    always_comb begin
        base = rd_stb ? '0 : msr_q;
    end

    msr_next_calc u_calc (
        .base  (base),
        .ctl   (mcr_ctl),
        .track (loop_on),
        .next  (msr_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) msr_q <= '0;
        else        msr_q <= msr_d;
    end

    always_comb begin
        msr = msr_q;
    end
endmodule

// File: rtl/msr_loopback_chk.sv
module msr_loopback_chk
    import msr_loop_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             loop_on,
    input logic [CTL_W-1:0] mcr_ctl,
    input logic             rd_stb,
    input logic [MSR_W-1:0] msr
);
    // R3
    level_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loop_on) |-> msr[7:4] == {$past(mcr_ctl[C_AUX2]), $past(mcr_ctl[C_AUX1]),
                                        $past(mcr_ctl[C_DTR]), $past(mcr_ctl[C_RTS])});
    // R5
    ring_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(loop_on) && !$past(rd_stb) && $past(msr[6]) && !$past(mcr_ctl[C_AUX1])) |-> msr[2]);
    // R6
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_stb) |-> ((msr[3:0] & $past(msr[3:0])) == $past(msr[3:0])));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(loop_on) && !$past(rd_stb)) |-> $stable(msr));
    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(loop_on) && $past(rd_stb)) |-> msr == '0);
    // R7
    read_zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(loop_on) && $past(rd_stb)) |-> !msr[2]);
endmodule

bind msr_loopback_gen msr_loopback_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .loop_on (loop_on),
    .mcr_ctl (mcr_ctl),
    .rd_stb  (rd_stb),
    .msr     (msr)
);

// File: tb/msr_loopback_gen_tb.sv
module msr_loopback_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loop_en = 1'b0;
    logic [3:0] mcr_ctl = 4'h0;
    logic       rd_stb = 1'b0;
    logic [7:0] msr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // reference state
    bit         m_track = 1'b0;
    logic [7:0] m_msr   = 8'h00;

    msr_loopback_gen u_dut (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
        .mcr_ctl(mcr_ctl), .rd_stb(rd_stb), .msr(msr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: msr actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected byte
    task automatic step(input bit le, input logic [3:0] c, input bit rd, input string tag);
        logic [7:0] b;
        logic [3:0] lv;
        logic [3:0] fl;
        @(negedge clk);
        loop_en = le; mcr_ctl = c; rd_stb = rd;
        @(posedge clk);
        #1;
        b = rd ? 8'h00 : m_msr;
        if (m_track) begin
            lv = {c[3], c[2], c[0], c[1]};
            fl = b[3:0];
            if (lv[0] != b[4]) fl[0] = 1'b1;
            if (lv[1] != b[5]) fl[1] = 1'b1;
            if (b[6] && !lv[2]) fl[2] = 1'b1;
            if (lv[3] != b[7]) fl[3] = 1'b1;
            m_msr = {lv, fl};
        end else begin
            m_msr = b;
        end
        m_track = le;
        exp_q.push_back(m_msr);
        tag_q.push_back(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                check(msr, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(msr, 8'h00, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(msr, 8'h00, "R1 after release");

        step(1, 4'hF, 0, "R2 enable lag");           // 00
        step(1, 4'hF, 0, "R3 R4 first track");       // FB
        step(1, 4'hF, 1, "R7 read reload");          // FB
        step(1, 4'h0, 1, "R7 read to zero");         // 00
        step(1, 4'h4, 0, "R5 no rising flag");       // 40
        step(1, 4'h0, 0, "R5 trailing flag");        // 04
        step(1, 4'h1, 0, "R4 DSR flag");             // 26
        step(1, 4'h0, 0, "R6 sticky");               // 06
        step(1, 4'h0, 1, "R7 clear");                // 00
        step(1, 4'h8, 0, "R4 DCD flag");             // 88
        step(1, 4'h2, 0, "R4 CTS and DCD");          // 19
        step(0, 4'hF, 0, "R2 disable lag");          // FB
        step(0, 4'h0, 0, "R8 hold");                 // FB
        step(0, 4'h5, 0, "R8 hold ctl");             // FB
        step(0, 4'h5, 1, "R8 read clears");          // 00
        step(0, 4'hF, 0, "R8 stays zero");           // 00
        @(negedge clk);
        rd_stb = 1'b0;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule